// File: doc/BRIEF.md
# Programmable DRAM Strobe Timing Sequencer

This block generates the active-low row and column strobes for a fast-page-mode or EDO DRAM controller. Every phase length is exact to the clock. A request starts one of three operations: a single-beat access, a page-mode burst of two to four beats, or a column-before-row refresh. Each strobe phase lasts for a number of clocks that comes from a packed configuration code. In every code field, the all-zeros code stands for the largest count the field can hold.

Before a request is taken, the configuration is checked. The column precharge code is legal only at two values. When error correction is on, the page-mode column length plus the precharge length must come to four clocks. A broken rule raises an error flag and the request is turned away. An accepted request copies the decoded lengths into internal registers. From then on the operation runs from those copies, and changes on the inputs do not affect it. A data strobe marks the last clock of each column assertion so the datapath can capture one word per beat. A done pulse closes every operation.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset, `ras_n_o` and `cas_n_o` are 1, and `dstb_o` and `done_o` are 0.
- R2: Every length code decodes to its own value, except code 0. For the 3-bit column fields, code 0 gives 8 clocks. For the 4-bit refresh row field, code 0 gives 16 clocks.
- R3: `refresh_i`=0 with `beats_i`=0 requests a single-beat access. Take t=0 as the first clock after the accepting edge. RAS is low alone for 1 clock. Then CAS is also low for the first-access length. Then both strobes go high.
- R4: `beats_i`=b with `refresh_i`=0 gives b+1 beats. After the first column assertion, each further beat holds CAS high for the precharge length and then low for the page-mode length. RAS stays low throughout.
- R5: `refresh_i`=1 requests a refresh. CAS goes low alone for 1 clock. Then RAS is also low for the refresh length. Then both strobes rise together.
- R6: `dstb_o` is high for exactly the last clock of each CAS assertion in an access, and it is never high during a refresh.
- R7: `done_o` is a 1-clock pulse on the clock just after the last strobe phase, with both strobes high. The sequencer is idle on the next clock.
- R8: Precharge code 1 means 1 clock and code 2 means 2 clocks. Every other precharge code (0, 3 to 7) sets `cfg_err_o`.
- R9: With `ecc_en_i`=1, `cfg_err_o` is set whenever the decoded page-mode length plus the decoded precharge length is not 4.
- R10: A start request seen while `cfg_err_o` is 1 is refused. The strobes stay high and no done pulse follows.
- R11: Field values are captured when a request is accepted. Field changes during an operation do not alter its timing.
- R12: A start request during an operation, including its done clock, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request an operation (taken only when idle) |
| refresh_i | input | 1 | 1 = refresh, 0 = access |
| beats_i | input | BEAT_W | Access beats minus one |
| ras_code_i | input | RAS_W | Refresh row-hold length code |
| cas_first_i | input | CAS_W | First-access column length code |
| cas_page_i | input | CAS_W | Page-mode column length code |
| cas_pre_i | input | CAS_W | Column precharge length code |
| ecc_en_i | input | 1 | Error correction enabled |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| dstb_o | output | 1 | Per-beat data strobe |
| done_o | output | 1 | Operation complete pulse |
| cfg_err_o | output | 1 | Current configuration is illegal |

## Verification
The strobes, the data strobe and the done pulse are all decoded from registered state. The bench therefore treats the clock just after the accepting edge as t=0 and compares all four outputs on every clock up to the done index plus one idle clock. That done index is 1+L1+(n-1)(P+Lp) for an access and R+1 for a refresh. Sampling happens at falling edges, after the rising edge has settled. `cfg_err_o` is combinational from the fields, so it is checked a short delay after the fields change. A refused request is watched for several clocks while start is held high.

// File: rtl/dss_pkg.sv
package dss_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ROW      = 3'd1,
        ST_CAS_ON   = 3'd2,
        ST_CAS_OFF  = 3'd3,
        ST_REF_LEAD = 3'd4,
        ST_REF_HOLD = 3'd5,
        ST_DONE     = 3'd6
    } dss_state_e;

endpackage

// File: rtl/dss_field_decode.sv
module dss_field_decode #(
    parameter int CODE_W = 3,
    parameter int LEN_W  = CODE_W + 1
) (
    input  logic [CODE_W-1:0] code_i,
    output logic [LEN_W-1:0]  len_o
);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(1) << CODE_W;

    always_comb begin
        if (code_i == '0) begin
            len_o = MAX_LEN;
        end else begin
            len_o = LEN_W'(code_i);
        end
    end
endmodule

// File: rtl/dss_rule_check.sv
module dss_rule_check #(
    parameter int CAS_W   = 3,
    parameter int LEN_W   = CAS_W + 1,
    parameter int ECC_SUM = 4
) (
    input  logic [CAS_W-1:0] pre_code_i,
    input  logic [LEN_W-1:0] page_len_i,
    input  logic [LEN_W-1:0] pre_len_i,
    input  logic             ecc_en_i,
    output logic             err_o
);
    localparam int SUM_W = LEN_W + 1;

    logic             pre_bad;
    logic [SUM_W-1:0] sum;

    always_comb begin
        pre_bad = !((pre_code_i == CAS_W'(1)) || (pre_code_i == CAS_W'(2)));
        sum     = SUM_W'(page_len_i) + SUM_W'(pre_len_i);
        err_o   = pre_bad || (ecc_en_i && (sum != SUM_W'(ECC_SUM)));
    end
endmodule

// File: rtl/dss_phase_timer.sv
module dss_phase_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));

    assert_len_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (val_i != '0));

    assert_last_then_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !load_i) |=> !last_o);
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
    import dss_pkg::*;
#(
    parameter int RAS_W   = 4,
    parameter int CAS_W   = 3,
    parameter int BEAT_W  = 2,
    parameter int ECC_SUM = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              refresh_i,
    input  logic [BEAT_W-1:0] beats_i,
    input  logic [RAS_W-1:0]  ras_code_i,
    input  logic [CAS_W-1:0]  cas_first_i,
    input  logic [CAS_W-1:0]  cas_page_i,
    input  logic [CAS_W-1:0]  cas_pre_i,
    input  logic              ecc_en_i,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              dstb_o,
    output logic              done_o,
    output logic              cfg_err_o
);
    localparam int RLEN_W = RAS_W + 1;
    localparam int CLEN_W = CAS_W + 1;
    localparam int CNT_W  = (RLEN_W > CLEN_W) ? RLEN_W : CLEN_W;

    typedef struct packed {
        dss_state_e        st;
        logic [CNT_W-1:0]  l1;
        logic [CNT_W-1:0]  lp;
        logic [CNT_W-1:0]  pre;
        logic [CNT_W-1:0]  ras;
        logic [BEAT_W-1:0] left;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [RLEN_W-1:0] ras_len;
    logic [CLEN_W-1:0] first_len, page_len, pre_len;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_last;

    dss_field_decode #(.CODE_W(RAS_W), .LEN_W(RLEN_W)) u_dec_ras (
        .code_i(ras_code_i), .len_o(ras_len));
    dss_field_decode #(.CODE_W(CAS_W), .LEN_W(CLEN_W)) u_dec_first (
        .code_i(cas_first_i), .len_o(first_len));
    dss_field_decode #(.CODE_W(CAS_W), .LEN_W(CLEN_W)) u_dec_page (
        .code_i(cas_page_i), .len_o(page_len));
    dss_field_decode #(.CODE_W(CAS_W), .LEN_W(CLEN_W)) u_dec_pre (
        .code_i(cas_pre_i), .len_o(pre_len));

    dss_rule_check #(.CAS_W(CAS_W), .LEN_W(CLEN_W), .ECC_SUM(ECC_SUM)) u_rules (
        .pre_code_i (cas_pre_i),
        .page_len_i (page_len),
        .pre_len_i  (pre_len),
        .ecc_en_i   (ecc_en_i),
        .err_o      (cfg_err_o)
    );

    dss_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .last_o (tmr_last)
    );

    always_comb begin
        ctx_d    = ctx_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                if (start_i && !cfg_err_o) begin
                    ctx_d.l1   = CNT_W'(first_len);
                    ctx_d.lp   = CNT_W'(page_len);
                    ctx_d.pre  = CNT_W'(pre_len);
                    ctx_d.ras  = CNT_W'(ras_len);
                    ctx_d.left = beats_i;
                    ctx_d.st   = refresh_i ? ST_REF_LEAD : ST_ROW;
                end
            end
            ST_ROW: begin
                ctx_d.st = ST_CAS_ON;
                tmr_load = 1'b1;
                tmr_val  = ctx_q.l1;
            end
            ST_CAS_ON: begin
                if (tmr_last) begin
                    if (ctx_q.left != '0) begin
                        ctx_d.st = ST_CAS_OFF;
                        tmr_load = 1'b1;
                        tmr_val  = ctx_q.pre;
                    end else begin
                        ctx_d.st = ST_DONE;
                    end
                end
            end
            ST_CAS_OFF: begin
                if (tmr_last) begin
                    ctx_d.st   = ST_CAS_ON;
                    ctx_d.left = ctx_q.left - BEAT_W'(1);
                    tmr_load   = 1'b1;
                    tmr_val    = ctx_q.lp;
                end
            end
            ST_REF_LEAD: begin
                ctx_d.st = ST_REF_HOLD;
                tmr_load = 1'b1;
                tmr_val  = ctx_q.ras;
            end
            ST_REF_HOLD: begin
                if (tmr_last) begin
                    ctx_d.st = ST_DONE;
                end
            end
            ST_DONE: begin
                ctx_d.st = ST_IDLE;
            end
            default: begin
                ctx_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '0;
        end else begin
            ctx_q <= ctx_d;
        end
    end

    always_comb begin
        ras_n_o = !((ctx_q.st == ST_ROW) || (ctx_q.st == ST_CAS_ON) ||
                    (ctx_q.st == ST_CAS_OFF) || (ctx_q.st == ST_REF_HOLD));
        cas_n_o = !((ctx_q.st == ST_CAS_ON) || (ctx_q.st == ST_REF_LEAD) ||
                    (ctx_q.st == ST_REF_HOLD));
        dstb_o  = (ctx_q.st == ST_CAS_ON) && tmr_last;
        done_o  = (ctx_q.st == ST_DONE);
    end

    // Data strobe only inside an access column assertion
    assert_dstb_in_cas_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dstb_o |-> (!cas_n_o && !ras_n_o));

    assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ras_n_o && cas_n_o && !dstb_o));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ref_lead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n_o && ras_n_o) |=> (!cas_n_o && !ras_n_o));

    assert_refuse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_IDLE && start_i && cfg_err_o) |=> (ras_n_o && cas_n_o && !done_o));

    assert_beat_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctx_q.st == ST_CAS_OFF) |-> (ctx_q.left != '0));
endmodule

// File: tb/dram_strobe_seq_bench.sv
module dram_strobe_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       refr = 1'b0;
    logic [1:0] beats = '0;
    logic [3:0] ras_code = 4'd1;
    logic [2:0] first_code = 3'd1;
    logic [2:0] page_code = 3'd1;
    logic [2:0] pre_code = 3'd1;
    logic       ecc = 1'b0;
    logic       ras_n, cas_n, dstb, done, cfg_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_strobe_seq u_dram_strobe_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .refresh_i(refr), .beats_i(beats),
        .ras_code_i(ras_code), .cas_first_i(first_code), .cas_page_i(page_code),
        .cas_pre_i(pre_code), .ecc_en_i(ecc),
        .ras_n_o(ras_n), .cas_n_o(cas_n), .dstb_o(dstb), .done_o(done), .cfg_err_o(cfg_err)
    );

    function automatic int dec(input int code, input int w);
        return (code == 0) ? (1 << w) : code;
    endfunction

    // {ras_n, cas_n, dstb, done} expected at clock t after acceptance
    function automatic logic [3:0] exp_at(input bit rf, input int n, input int l1,
                                          input int lp, input int p, input int r, input int t);
        int pos;
        int len;
        if (rf) begin
            if (t == 0) return 4'b1000;
            if (t <= r) return 4'b0000;
            if (t == r + 1) return 4'b1101;
            return 4'b1100;
        end
        if (t == 0) return 4'b0100;
        pos = 1;
        len = l1;
        for (int b = 0; b < n; b++) begin
            if (b > 0) begin
                if (t < pos + p) return 4'b0100;
                pos = pos + p;
                len = lp;
            end
            if (t < pos + len) return {2'b00, (t == pos + len - 1), 1'b0};
            pos = pos + len;
        end
        if (t == pos) return 4'b1101;
        return 4'b1100;
    endfunction

    function automatic bit exp_err(input int pc, input int pgc, input bit e);
        bit bad_pre;
        bad_pre = !(pc == 1 || pc == 2);
        return bad_pre || (e && (dec(pgc, 3) + dec(pc, 3) != 4));
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic run_op(input bit rf, input int bc, input int rc, input int fc,
                          input int pgc, input int prc, input bit e, input bit disturb,
                          input string tag);
        int n, l1, lp, p, r, last_t;
        logic [3:0] got, want;
        bit bad;
        logic [3:0] bad_got, bad_want;
        n  = bc + 1;
        l1 = dec(fc, 3);
        lp = dec(pgc, 3);
        p  = dec(prc, 3);
        r  = dec(rc, 4);
        last_t = rf ? r + 1 : 1 + l1 + (n - 1) * (p + lp);
        bad = 1'b0;
        bad_got = '0;
        bad_want = '0;
        @(negedge clk);
        refr = rf; beats = 2'(bc); ras_code = 4'(rc); first_code = 3'(fc);
        page_code = 3'(pgc); pre_code = 3'(prc); ecc = e; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int t = 0; t <= last_t + 1; t++) begin
            got  = {ras_n, cas_n, dstb, done};
            want = exp_at(rf, n, l1, lp, p, r, t);
            if (got !== want && !bad) begin
                bad = 1'b1;
                bad_got = got;
                bad_want = want;
                $display("  at t=%0d of %s", t, tag);
            end
            if (disturb && t == 1) begin
                start = 1'b1;
                refr = ~refr;
                beats = ~beats;
                ras_code = 4'($urandom);
                first_code = 3'($urandom);
                page_code = 3'($urandom);
                pre_code = 3'($urandom);
            end
            if (disturb && t == 3) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        check(!bad, tag, int'(bad_got), int'(bad_want));
    endtask

    task automatic check_err(input int prc, input int pgc, input bit e, input string tag);
        @(negedge clk);
        pre_code = 3'(prc); page_code = 3'(pgc); ecc = e;
        #1;
        check(cfg_err === exp_err(prc, pgc, e), tag, int'(cfg_err), int'(exp_err(prc, pgc, e)));
    endtask

    task automatic run_refused(input int prc, input int pgc, input bit e, input string tag);
        bit bad;
        @(negedge clk);
        refr = 1'b0; beats = 2'd3; first_code = 3'd2; ras_code = 4'd3;
        pre_code = 3'(prc); page_code = 3'(pgc); ecc = e; start = 1'b1;
        bad = 1'b0;
        for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            if ({ras_n, cas_n, dstb, done} !== 4'b1100) bad = 1'b1;
        end
        start = 1'b0;
        check(!bad, tag, int'({ras_n, cas_n, dstb, done}), 4'hC);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int rc, fc, pgc, prc, bc;
        bit e, rf;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check({ras_n, cas_n, dstb, done} === 4'b1100, "R1 reset strobes",
              int'({ras_n, cas_n, dstb, done}), 4'hC);

        // R3 single beats, shortest and zero-code longest
        run_op(1'b0, 0, 1, 1, 1, 1, 1'b0, 1'b0, "R3 single len1");
        run_op(1'b0, 0, 1, 0, 1, 2, 1'b0, 1'b0, "R3 R2 single code0 = 8");
        // R4 R6 bursts
        run_op(1'b0, 3, 1, 2, 3, 1, 1'b1, 1'b0, "R4 R6 burst 4 ecc");
        run_op(1'b0, 1, 1, 3, 2, 2, 1'b1, 1'b0, "R4 burst 2 ecc");
        run_op(1'b0, 3, 1, 0, 0, 2, 1'b0, 1'b0, "R4 R2 burst code0 page");
        // R5 refresh including 16-clock code 0
        run_op(1'b1, 0, 5, 1, 1, 1, 1'b0, 1'b0, "R5 R6 refresh 5");
        run_op(1'b1, 2, 0, 1, 1, 2, 1'b0, 1'b0, "R5 R2 refresh code0 = 16");
        run_op(1'b1, 0, 1, 1, 3, 1, 1'b1, 1'b0, "R5 refresh shortest");
        // R11 R12 field changes and restarts during an operation
        run_op(1'b0, 2, 1, 4, 3, 1, 1'b0, 1'b1, "R11 R12 burst disturbed");
        run_op(1'b1, 0, 7, 1, 1, 2, 1'b0, 1'b1, "R11 R12 refresh disturbed");
        run_op(1'b0, 0, 1, 1, 1, 1, 1'b0, 1'b1, "R12 single disturbed");

        // R8 precharge legality, R9 sum rule
        check_err(1, 1, 1'b0, "R8 pre code1 legal");
        check_err(2, 5, 1'b0, "R8 pre code2 legal");
        check_err(0, 1, 1'b0, "R8 pre code0 reserved");
        check_err(3, 1, 1'b0, "R8 pre code3 reserved");
        check_err(7, 1, 1'b0, "R8 pre code7 reserved");
        check_err(1, 3, 1'b1, "R9 ecc 3+1 ok");
        check_err(2, 2, 1'b1, "R9 ecc 2+2 ok");
        check_err(2, 3, 1'b1, "R9 ecc 3+2 bad");
        check_err(1, 0, 1'b1, "R9 ecc 8+1 bad");
        check_err(2, 3, 1'b0, "R9 ecc off 3+2 ok");

        // R10 refusal
        run_refused(4, 1, 1'b0, "R10 refuse reserved pre");
        run_refused(1, 1, 1'b1, "R10 refuse ecc sum");
        run_op(1'b0, 1, 1, 2, 2, 2, 1'b1, 1'b0, "R10 legal after refusal");

        // Constrained random legal operations
        for (int i = 0; i < 40; i++) begin
            rf  = ($urandom % 4) == 0;
            bc  = $urandom % 4;
            rc  = $urandom % 16;
            fc  = $urandom % 8;
            prc = 1 + ($urandom % 2);
            e   = $urandom % 2;
            pgc = e ? (4 - prc) : ($urandom % 8);
            run_op(rf, bc, rc, fc, pgc, prc, e, ($urandom % 4) == 0,
                   rf ? "R5 random refresh" : "R4 R3 random access");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule